// File: doc/BRIEF.md
# Watchdog Timer with Grace-Window Reset

This block is a watchdog counter that runs on the slow watchdog clock. Software sets it up through one control word. The word holds a timeout selector, enables for counting, interrupt, wake-up and reset, and three event flags that clear when a one is written to them. A separate restart strobe clears the running count. When the chosen power-of-two interval has passed, the block raises its interrupt flag and, if enabled, its wake flag.

The timeout does not reset the system at once. It first opens a grace window of fixed length. If no restart arrives before the window closes, and reset is enabled, the block pulses a system reset request for one cycle and records a reset flag. A restart inside the window cancels the reset. Software can use the interrupt to restart the counter in time, or it can chain several short intervals into a longer one.

Control word layout (write data and readback share it): bits [2:0] timeout select, bit 3 count enable, bit 4 interrupt enable, bit 5 wake enable, bit 6 reset enable, bit 7 interrupt flag, bit 8 wake flag, bit 9 reset flag.

Top module: `wdg_grace_top`

## Requirements
- R1: With count enable (bit 3) set, the timeout event happens on the 2^(4+2*S)-th enabled clock edge after counting starts from zero, where S is the select value in bits [2:0] (16, 64, 256 … 262144 clocks).
- R2: The interrupt flag (bit 7) sets on the timeout edge. `irq_o` is high exactly when both the flag and interrupt enable (bit 4) are set, and it updates on the same edge as either of them.
- R3: The wake flag (bit 8), mirrored on `wake_o`, sets on a timeout only while wake enable (bit 5) is set.
- R4: 130 clocks after the timeout edge, if no restart has arrived and reset enable (bit 6) is set, `sysrst_o` pulses high for exactly one cycle and the reset flag (bit 9) sets. With reset enable clear, neither happens.
- R5: A restart strobe clears the count, so the next timeout comes a full interval after the strobe. It also cancels an open grace window.
- R6: Writing one to a flag bit clears that flag. Writing zero leaves it unchanged. If a timeout and a clearing write fall on the same edge, the flag ends up set.
- R7: Writing count enable as zero stops counting and clears both the count and any open grace window. No new events follow while the counter is stopped.
- R8: A write that changes the timeout select restarts the count from zero, so the new interval is measured from that write.
- R9: After reset the readback word is all zeros and `irq_o`, `wake_o` and `sysrst_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Single-cycle control word write strobe |
| cfg_wdata | input | 10 | Control word write data |
| kick_i | input | 1 | Counter restart strobe |
| cfg_rdata | output | 10 | Control word and flag readback |
| irq_o | output | 1 | Timeout interrupt (flag AND enable) |
| wake_o | output | 1 | Wake-up flag |
| sysrst_o | output | 1 | One-cycle system reset request |

## Verification
The assertions assume that `cfg_we` and `kick_i` are synchronous to `clk` and last one cycle each. They also assume the select field changes only through a write, so the count always stays below the active limit. The bench drives every strobe on the falling edge for exactly one cycle and samples on the falling edge. It uses only the short intervals (16, 64 and 256 clocks) so that each scenario, including the 130-clock window, fits in a few hundred cycles. The clear-versus-set collision is placed by counting edges from the enabling write.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int TSEL_W = 3;
  localparam int CTRL_W = 10;

  typedef struct packed {
    logic              rst_en;
    logic              wake_en;
    logic              irq_en;
    logic              cnt_en;
    logic [TSEL_W-1:0] tsel;
  } wdg_ctrl_t;

  typedef struct packed {
    logic rst_f;
    logic wake_f;
    logic irq_f;
  } wdg_flags_t;
endpackage

// File: rtl/wdg_interval_cnt.sv
module wdg_interval_cnt
  import wdg_pkg::*;
#(
  parameter int BASE_EXP = 4,
  parameter int EXP_STEP = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              clr,
  input  logic [TSEL_W-1:0] tsel,
  output logic              tout
);
  localparam int NSEL  = 1 << TSEL_W;
  localparam int CNT_W = BASE_EXP + EXP_STEP * (NSEL - 1) + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim_m1 [NSEL];

  for (genvar i = 0; i < NSEL; i++) begin : g_lim
    assign lim_m1[i] = CNT_W'((64'd1 << (BASE_EXP + EXP_STEP * i)) - 64'd1);
  end

  assign tout = en && !clr && (cnt == lim_m1[tsel]);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (en) begin
      cnt <= tout ? '0 : cnt + 1'b1;
    end
  end

  assert_cnt_below_limit_R1: assert property (@(posedge clk) disable iff (rst)
    cnt <= lim_m1[tsel]);

  assert_stopped_cnt_zero_R7: assert property (@(posedge clk) disable iff (rst)
    !en |-> (cnt == '0));

  assert_clr_zeroes_R5: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));
endmodule

// File: rtl/wdg_grace.sv
module wdg_grace #(
  parameter int DELAY = 130
) (
  input  logic clk,
  input  logic rst,
  input  logic tout,
  input  logic kill,
  input  logic rst_en,
  output logic rst_set,
  output logic sysrst_o
);
  localparam int GW = $clog2(DELAY);

  logic          active;
  logic [GW-1:0] gcnt;
  logic          last;

  assign last    = active && !kill && (gcnt == GW'(DELAY - 1));
  assign rst_set = last && rst_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      gcnt     <= '0;
      sysrst_o <= 1'b0;
    end else begin
      sysrst_o <= rst_set;
      if (kill) begin
        active <= 1'b0;
        gcnt   <= '0;
      end else if (active) begin
        if (last) begin
          active <= 1'b0;
          gcnt   <= '0;
        end else begin
          gcnt <= gcnt + 1'b1;
        end
      end else if (tout) begin
        active <= 1'b1;
        gcnt   <= '0;
      end
    end
  end

  assert_rst_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    sysrst_o |=> !sysrst_o);

  assert_kill_closes_window_R5: assert property (@(posedge clk) disable iff (rst)
    kill |=> (!active && !sysrst_o));
endmodule

// File: rtl/wdg_ctrl_regs.sv
module wdg_ctrl_regs
  import wdg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              tout,
  input  logic              rst_set,
  output wdg_ctrl_t         ctrl,
  output wdg_flags_t        flags,
  output logic              restart,
  output logic              irq_o
);
  wdg_ctrl_t  ctrl_n;
  wdg_flags_t flags_n;
  wdg_flags_t w1c;
  wdg_ctrl_t  wctrl;

  assign wctrl   = wdg_ctrl_t'(wdata[6:0]);
  assign restart = wr && ((wctrl.tsel != ctrl.tsel) || !wctrl.cnt_en);

  always_comb begin
    ctrl_n       = wr ? wctrl : ctrl;
    w1c          = wr ? wdg_flags_t'(wdata[9:7]) : '0;
    flags_n      = flags & ~w1c;
    flags_n.irq_f  = flags_n.irq_f  | tout;
    flags_n.wake_f = flags_n.wake_f | (tout && ctrl.wake_en);
    flags_n.rst_f  = flags_n.rst_f  | rst_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl  <= '0;
      flags <= '0;
      irq_o <= 1'b0;
    end else begin
      ctrl  <= ctrl_n;
      flags <= flags_n;
      irq_o <= flags_n.irq_f && ctrl_n.irq_en;
    end
  end

  assert_irq_needs_enable_R2: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (ctrl.irq_en && flags.irq_f));

  assert_wake_on_timeout_R3: assert property (@(posedge clk) disable iff (rst)
    (tout && ctrl.wake_en) |=> flags.wake_f);

  assert_set_beats_clear_R6: assert property (@(posedge clk) disable iff (rst)
    tout |=> flags.irq_f);
endmodule

// File: rtl/wdg_grace_top.sv
module wdg_grace_top
  import wdg_pkg::*;
#(
  parameter int BASE_EXP = 4,
  parameter int EXP_STEP = 2,
  parameter int DELAY    = 130
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CTRL_W-1:0] cfg_wdata,
  input  logic              kick_i,
  output logic [CTRL_W-1:0] cfg_rdata,
  output logic              irq_o,
  output logic              wake_o,
  output logic              sysrst_o
);
  wdg_ctrl_t  ctrl;
  wdg_flags_t flags;
  logic       restart;
  logic       clr;
  logic       tout;
  logic       rst_set;

  assign clr = kick_i || restart;

  wdg_ctrl_regs u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr      (cfg_we),
    .wdata   (cfg_wdata),
    .tout    (tout),
    .rst_set (rst_set),
    .ctrl    (ctrl),
    .flags   (flags),
    .restart (restart),
    .irq_o   (irq_o)
  );

  wdg_interval_cnt #(
    .BASE_EXP (BASE_EXP),
    .EXP_STEP (EXP_STEP)
  ) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .en   (ctrl.cnt_en),
    .clr  (clr),
    .tsel (ctrl.tsel),
    .tout (tout)
  );

  wdg_grace #(
    .DELAY (DELAY)
  ) u_grace (
    .clk      (clk),
    .rst      (rst),
    .tout     (tout),
    .kill     (clr),
    .rst_en   (ctrl.rst_en),
    .rst_set  (rst_set),
    .sysrst_o (sysrst_o)
  );

  assign cfg_rdata = {flags, ctrl};
  assign wake_o    = flags.wake_f;

  assert_sysrst_sets_flag_R4: assert property (@(posedge clk) disable iff (rst)
    sysrst_o |-> flags.rst_f);
endmodule

// File: tb/wdg_grace_top_tb.sv
module wdg_grace_top_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [9:0] cfg_wdata = '0;
  logic       kick_i = 1'b0;
  logic [9:0] cfg_rdata;
  logic       irq_o;
  logic       wake_o;
  logic       sysrst_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdg_grace_top u_dut (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .kick_i    (kick_i),
    .cfg_rdata (cfg_rdata),
    .irq_o     (irq_o),
    .wake_o    (wake_o),
    .sysrst_o  (sysrst_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] d);
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic kick();
    kick_i = 1'b1;
    @(negedge clk);
    kick_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R9 rdata", cfg_rdata, 0);
    check("R9 irq", irq_o, 0);
    check("R9 wake", wake_o, 0);
    check("R9 sysrst", sysrst_o, 0);
  endtask

  task automatic t_full_path();
    wr(10'h078);
    repeat (15) @(negedge clk);
    check("R1 no early timeout", cfg_rdata[7], 0);
    @(negedge clk);
    check("R1 timeout at 16", cfg_rdata[7], 1);
    check("R2 irq out", irq_o, 1);
    check("R3 wake out", wake_o, 1);
    repeat (129) @(negedge clk);
    check("R4 no early reset", sysrst_o, 0);
    check("R4 flag not yet", cfg_rdata[9], 0);
    @(negedge clk);
    check("R4 reset at 130", sysrst_o, 1);
    check("R4 reset flag", cfg_rdata[9], 1);
    @(negedge clk);
    check("R4 one-cycle pulse", sysrst_o, 0);
  endtask

  task automatic t_w1c_stop();
    int seen = 0;
    wr(10'h000);
    check("R6 zero write keeps flags", cfg_rdata, 10'h380);
    check("R2 irq off without enable", irq_o, 0);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (sysrst_o) seen++;
    end
    check("R7 stopped: no reset", seen, 0);
    check("R7 stopped: flags stable", cfg_rdata, 10'h380);
    wr(10'h080);
    check("R6 clear irq only", cfg_rdata, 10'h300);
    wr(10'h300);
    check("R6 clear rest", cfg_rdata, 0);
  endtask

  task automatic t_irq_gate();
    wr(10'h009);
    repeat (63) @(negedge clk);
    check("R1 no timeout at 63", cfg_rdata[7], 0);
    @(negedge clk);
    check("R1 timeout at 64", cfg_rdata[7], 1);
    check("R2 irq masked", irq_o, 0);
    wr(10'h019);
    check("R2 irq after enable", irq_o, 1);
    wr(10'h380);
    check("R7 stop and clear", cfg_rdata, 0);
  endtask

  task automatic t_kick_cancel();
    int seen = 0;
    wr(10'h04A);
    repeat (256) @(negedge clk);
    check("R1 timeout at 256", cfg_rdata[7], 1);
    wr(10'h0CA);
    check("R6 irq cleared", cfg_rdata[7], 0);
    repeat (100) @(negedge clk);
    kick();
    for (int i = 0; i < 255; i++) begin
      if (sysrst_o || cfg_rdata[9] || cfg_rdata[7]) seen++;
      @(negedge clk);
    end
    check("R5 window cancelled, count restarted", seen, 0);
    @(negedge clk);
    check("R5 timeout 256 after kick", cfg_rdata[7], 1);
    wr(10'h380);
  endtask

  task automatic t_no_rst_en();
    int seen = 0;
    wr(10'h008);
    repeat (16) @(negedge clk);
    check("R1 timeout", cfg_rdata[7], 1);
    for (int i = 0; i < 140; i++) begin
      @(negedge clk);
      if (sysrst_o) seen++;
    end
    check("R4 no pulse when disabled", seen, 0);
    check("R4 no flag when disabled", cfg_rdata[9], 0);
    wr(10'h380);
  endtask

  task automatic t_tsel_change();
    int early = 0;
    wr(10'h00A);
    repeat (200) @(negedge clk);
    wr(10'h009);
    for (int i = 0; i < 63; i++) begin
      if (cfg_rdata[7]) early++;
      @(negedge clk);
    end
    check("R8 no stale timeout", early, 0);
    @(negedge clk);
    check("R8 new interval from write", cfg_rdata[7], 1);
    wr(10'h380);
  endtask

  task automatic t_wake_off();
    wr(10'h018);
    repeat (16) @(negedge clk);
    check("R2 irq", irq_o, 1);
    check("R3 no wake when disabled", wake_o, 0);
    wr(10'h380);
  endtask

  task automatic t_set_wins();
    wr(10'h008);
    repeat (15) @(negedge clk);
    wr(10'h088);
    check("R6 set beats clear", cfg_rdata[7], 1);
    wr(10'h380);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_full_path();
    t_w1c_stop();
    t_irq_gate();
    t_kick_cancel();
    t_no_rst_en();
    t_tsel_change();
    t_wake_off();
    t_set_wins();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule